// File: doc/BRIEF.md
# Ultra DMA Read-Burst Listener

This block sits beside a parallel ATA cable and records the data a drive returns during Ultra DMA read bursts. It only listens and never drives any bus line. The handshake lines and the 16-bit data bus reach it from the cable without any relation to its own clock. Each line passes through a synchronizer chain before the block uses it.

After reset the listener does nothing. An arm pulse, raised by whatever logic decodes the host's setup message, moves it through a one-cycle setup state into a watching state. While watching, it waits for a qualified read burst. A qualified burst has the device requesting, the host acknowledging, the host not asking to stop and the host ready to receive. Inside a burst, every change of the device strobe in either direction yields one captured word with a one-cycle valid flag. The burst ends when the host asks to stop or when the request or acknowledge is withdrawn, and the block then returns to watching. A disarm pulse sends it back to the quiet state from anywhere.

Top module: `udma_snoop`

## Requirements
- R1: After reset `snoop_state` is 0 (quiet) and `word_valid` is 0.
- R2: In the quiet state (0) the block ignores bus activity: the state stays 0 and no word is produced until `arm_cmd` is raised.
- R3: `arm_cmd` in state 0 gives state 1 (setup) on the next clock, and state 1 always gives state 2 (watching) on the clock after.
- R4: From state 2 the block enters state 3 (burst) only when the synchronized request=1, acknowledge=1, stop=0 and ready=1 all hold together. If any one is missing it stays in state 2.
- R5: In state 3 both a rising and a falling strobe change each produce one captured word, equal to `bus_data` as it was when the strobe changed.
- R6: `word_valid` is high for exactly one clock for each strobe change.
- R7: In state 3, a synchronized stop of 1, a request of 0 or an acknowledge of 0 returns the block to state 2.
- R8: A strobe change seen in the same cycle as the end of a burst is still delivered as a word.
- R9: No word is produced while the block is outside state 3.
- R10: `disarm` returns the block to state 0 on the next clock from any state, and it wins over a simultaneous `arm_cmd`.
- R11: Each bus input takes SYNC_STAGES clocks to reach the block's logic. A bus change therefore shows in `snoop_state`, and in `word_valid` for a strobe change, on the (SYNC_STAGES+1)-th rising clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_cmd | input | 1 | One-cycle arm request (local clock domain) |
| disarm | input | 1 | One-cycle return-to-quiet request (local clock domain) |
| dev_dma_req | input | 1 | Device DMA request line from the cable |
| host_dma_ack | input | 1 | Host DMA acknowledge line from the cable |
| host_stop | input | 1 | Host stop-burst line from the cable |
| host_ready | input | 1 | Host ready-to-receive line from the cable |
| dev_strobe | input | 1 | Device data strobe from the cable |
| bus_data | input | 16 | Cable data bus |
| word_valid | output | 1 | One-cycle flag for a captured word |
| word_data | output | 16 | Captured word |
| snoop_state | output | 2 | Current state: 0 quiet, 1 setup, 2 watching, 3 burst |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a 16-bit word. With two stages every bus change reaches the outputs on the third rising clock, so the bench can check the latency edge by edge and can pin a strobe change and a stop in the same cycle. The 16-bit width allows all-zero, all-ones and alternating bit patterns, which would reveal a dropped or swapped data bit.

// File: rtl/udma_snoop_pkg.sv
package udma_snoop_pkg;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_SETUP = 2'd1,
        ST_WATCH = 2'd2,
        ST_BURST = 2'd3
    } snoop_state_e;

    // handshake lines after synchronization
    typedef struct packed {
        logic req;
        logic ack;
        logic stop;
        logic ready;
    } hs_lines_t;

endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/udma_edge.sv
module udma_edge #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              strobe_change,
    output logic [DATA_W-1:0] data_at_change
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = strobe_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // data went through the same synchronizer depth as the strobe
    assign strobe_change  = strobe_s ^ prev_q;
    assign data_at_change = data_s;
endmodule

// File: rtl/udma_ctrl.sv
module udma_ctrl
    import udma_snoop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_cmd,
    input  logic              disarm,
    input  hs_lines_t         hs,
    input  logic              strobe_change,
    input  logic [DATA_W-1:0] data_at_change,
    output snoop_state_e      state,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data
);
    typedef struct packed {
        snoop_state_e      st;
        logic              vld;
        logic [DATA_W-1:0] word;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       qualified, terminate;

    always_comb begin
        qualified = hs.req & hs.ack & ~hs.stop & hs.ready;
        terminate = hs.stop | ~hs.req | ~hs.ack;

        r_d     = r_q;
        r_d.vld = 1'b0;

        // capture uses the current state, so a word seen at termination survives
        if (r_q.st == ST_BURST && strobe_change) begin
            r_d.vld  = 1'b1;
            r_d.word = data_at_change;
        end

        unique case (r_q.st)
            ST_QUIET: if (arm_cmd)   r_d.st = ST_SETUP;
            ST_SETUP:                r_d.st = ST_WATCH;
            ST_WATCH: if (qualified) r_d.st = ST_BURST;
            ST_BURST: if (terminate) r_d.st = ST_WATCH;
            default:                 r_d.st = ST_QUIET;
        endcase

        if (disarm) r_d.st = ST_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_QUIET;
            r_q.vld  <= 1'b0;
            r_q.word <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state      = r_q.st;
    assign word_valid = r_q.vld;
    assign word_data  = r_q.word;
endmodule

// File: rtl/udma_snoop.sv
module udma_snoop
    import udma_snoop_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_cmd,
    input  logic              disarm,
    input  logic              dev_dma_req,
    input  logic              host_dma_ack,
    input  logic              host_stop,
    input  logic              host_ready,
    input  logic              dev_strobe,
    input  logic [DATA_W-1:0] bus_data,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic [1:0]        snoop_state
);
    localparam int HS_W  = $bits(hs_lines_t);
    localparam int BUS_W = HS_W + 1 + DATA_W;

    logic [BUS_W-1:0]  raw_bus, sync_bus;
    hs_lines_t         hs_raw, hs_s;
    logic              strobe_s, strobe_change;
    logic [DATA_W-1:0] data_s, data_at_change;
    snoop_state_e      st;

    always_comb begin
        hs_raw.req   = dev_dma_req;
        hs_raw.ack   = host_dma_ack;
        hs_raw.stop  = host_stop;
        hs_raw.ready = host_ready;
    end

    assign raw_bus = {hs_raw, dev_strobe, bus_data};

    udma_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign hs_s     = sync_bus[BUS_W-1 -: HS_W];
    assign strobe_s = sync_bus[DATA_W];
    assign data_s   = sync_bus[DATA_W-1:0];

    udma_edge #(.DATA_W(DATA_W)) u_edge (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_s       (strobe_s),
        .data_s         (data_s),
        .strobe_change  (strobe_change),
        .data_at_change (data_at_change)
    );

    udma_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm_cmd        (arm_cmd),
        .disarm         (disarm),
        .hs             (hs_s),
        .strobe_change  (strobe_change),
        .data_at_change (data_at_change),
        .state          (st),
        .word_valid     (word_valid),
        .word_data      (word_data)
    );

    assign snoop_state = st;
endmodule

// File: rtl/udma_snoop_chk.sv
module udma_snoop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm_cmd,
    input logic       disarm,
    input logic       word_valid,
    input logic [1:0] snoop_state
);
    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_state == 2'd0 && !arm_cmd) |=> (snoop_state == 2'd0));

    assert_setup_to_watch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_state == 2'd1 && !disarm) |=> (snoop_state == 2'd2));

    assert_burst_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snoop_state == 2'd3) |-> ($past(snoop_state) == 2'd2));

    assert_burst_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_state == 2'd3 && !disarm) |=> (snoop_state inside {2'd2, 2'd3}));

    assert_word_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(snoop_state) == 2'd3));

    assert_disarm_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (snoop_state == 2'd0));
endmodule

bind udma_snoop udma_snoop_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_cmd     (arm_cmd),
    .disarm      (disarm),
    .word_valid  (word_valid),
    .snoop_state (snoop_state)
);

// File: tb/tb_udma_snoop.sv
`timescale 1ns/1ps
module tb_udma_snoop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_cmd = 1'b0, disarm = 1'b0;
    logic        req = 1'b0, ack = 1'b0, stp = 1'b0, rdy = 1'b0, strb = 1'b0;
    logic [15:0] data = '0;
    logic        word_valid;
    logic [15:0] word_data;
    logic [1:0]  snoop_state;

    int n_chk = 0, n_bad = 0, valid_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    udma_snoop dut (
        .clk(clk), .rst_n(rst_n), .arm_cmd(arm_cmd), .disarm(disarm),
        .dev_dma_req(req), .host_dma_ack(ack), .host_stop(stp),
        .host_ready(rdy), .dev_strobe(strb), .bus_data(data),
        .word_valid(word_valid), .word_data(word_data),
        .snoop_state(snoop_state)
    );

    always @(negedge clk) if (word_valid) valid_seen++;

    localparam logic [15:0] WORDS [8] = '{
        16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A,
        16'h0001, 16'h8000, 16'h1234, 16'hFEDC
    };

    task automatic check(string req_tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // change strobe with new data, expect one word three edges later
    task automatic strobe_word(logic [15:0] w, string tag);
        data = w;
        strb = ~strb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, word_valid, 1);
        check({tag, " data"}, word_data, w);
        @(negedge clk);
        check("R6 one-cycle valid", word_valid, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seen;
        settle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 state", snoop_state, 0);
        check("R1 valid", word_valid, 0);

        // R2: quiet ignores bus traffic
        req = 1; ack = 1;
        strb = 1; settle(1); strb = 0; settle(1); strb = 1;
        settle(5);
        check("R2 state", snoop_state, 0);
        check("R2 no word", valid_seen, 0);

        // R3: arm -> setup -> watch
        arm_cmd = 1;
        @(posedge clk); @(negedge clk);
        arm_cmd = 0;
        check("R3 setup", snoop_state, 1);
        @(negedge clk);
        check("R3 watch", snoop_state, 2);

        // R4/R9: ready missing, strobes ignored
        strb = ~strb; settle(2); strb = ~strb;
        settle(5);
        check("R4 unqualified", snoop_state, 2);
        check("R9 no word outside burst", valid_seen, 0);

        // R11/R4: qualification latency
        rdy = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 not yet", snoop_state, 2);
        @(negedge clk);
        check("R4 burst", snoop_state, 3);

        // R5: table walk, alternating edge directions
        for (int i = 0; i < 8; i++) begin
            strobe_word(WORDS[i], "R5");
        end

        // R8/R7: word with stop in the same cycle
        stp = 1;
        strobe_word(16'hC3C3, "R8");
        check("R7 stop exit", snoop_state, 2);
        stp = 0; settle(4);
        check("R4 reentry", snoop_state, 3);
        req = 0; settle(4);
        check("R7 req exit", snoop_state, 2);
        req = 1; settle(4);
        check("R4 reentry2", snoop_state, 3);
        ack = 0; settle(4);
        check("R7 ack exit", snoop_state, 2);
        seen = valid_seen;
        strb = ~strb; settle(5);
        check("R9 no word in watch", valid_seen, seen);
        ack = 1; settle(4);
        check("R4 reentry3", snoop_state, 3);

        // R10: disarm from burst, priority over arm
        disarm = 1;
        @(posedge clk); @(negedge clk);
        check("R10 disarm", snoop_state, 0);
        arm_cmd = 1;
        @(posedge clk); @(negedge clk);
        check("R10 priority", snoop_state, 0);
        disarm = 0;
        @(posedge clk); @(negedge clk);
        arm_cmd = 0;
        check("R3 rearm", snoop_state, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule